// File: doc/BRIEF.md
# Addressable Output Latch with Demultiplexer Mode

This block drives a bank of eight output bits from one serial data bit. A binary select code picks the bit that a write touches. Two active-low controls choose one of four behaviours. In the write behaviour, one bit is updated and the other seven are left alone. In the hold behaviour, nothing changes. In the demultiplex behaviour, the data bit is steered onto the selected output and every other output is forced low. The clear behaviour zeroes the whole bank.

The model is fully synchronous. Every output is a flip-flop that updates on the rising edge of the system clock from the inputs sampled at that edge. A typical use is a control processor that sets individual enable lines one at a time. The same pins can also strobe a single line out of eight.

Top module: `addr_latch_demux`

## Requirements
- R1: With `en_n`=0 and `clr_n`=1 (write), the output bit selected by `sel_addr` takes the value of `din`, and every other output bit keeps its value.
- R2: With `en_n`=1 and `clr_n`=1 (hold), every output bit keeps its value whatever `sel_addr` and `din` are.
- R3: With `en_n`=0 and `clr_n`=0 (demultiplex), the selected output bit equals `din` and every other output bit is 0, so at most one output bit is high.
- R4: With `en_n`=1 and `clr_n`=0 (clear), all output bits become 0 whatever `sel_addr` and `din` are.
- R5: `sel_addr` is a natural binary number with bit 0 as the least significant bit. The value k selects `q_out[k]` for every k from 0 to 7.
- R6: Inputs are sampled on the rising edge of `clk`. The result is visible on `q_out` right after that same edge, one cycle after the inputs were applied, and consecutive write cycles each take effect.
- R7: A high `rst` at a rising edge sets all output bits to 0 and takes priority over every control combination.
- R8: A demultiplex cycle followed by hold cycles leaves the last one-hot (or all-zero) pattern on `q_out` unchanged.
- R9: Input rule: while the block stays in write mode on consecutive cycles, `sel_addr` must not change. The select code is moved only while the block is outside write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel_addr | input | 3 | Binary index of the target output bit |
| din | input | 1 | Serial data bit |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q_out | output | 8 | Registered parallel outputs |

## Verification
The assertions assume that the select code stays fixed across back-to-back write cycles, because a moving code during a write would land the data on an unintended bit. One property reports any such move. To stay inside this rule, the stimulus changes the code only during a hold, demultiplex or clear cycle and then enters write mode with the code already settled. The assertions also assume that reset is released while the controls request hold, so the first cycle after reset is never a write whose select code differs from the one before.

// File: rtl/alx_pkg.sv
package alx_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } alx_mode_e;

endpackage

// File: rtl/alx_mode_decode.sv
module alx_mode_decode
  import alx_pkg::*;
(
  input  logic      en_n,
  input  logic      clr_n,
  output alx_mode_e mode
);

  always_comb begin
    unique case ({en_n, clr_n})
      2'b01:   mode = MODE_WRITE;
      2'b11:   mode = MODE_HOLD;
      2'b00:   mode = MODE_DEMUX;
      default: mode = MODE_CLEAR;
    endcase
  end

endmodule

// File: rtl/alx_sel_decode.sv
module alx_sel_decode #(
  parameter int NUM_OUT = 8,
  localparam int ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic [ADDR_W-1:0]  sel,
  output logic [NUM_OUT-1:0] hit
);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_hit
    assign hit[k] = (sel == ADDR_W'(k));
  end

endmodule

// File: rtl/alx_bit_cell.sv
module alx_bit_cell
  import alx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  alx_mode_e mode,
  input  logic      hit,
  input  logic      din,
  output logic      q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    unique case (mode)
      MODE_WRITE: if (hit) q_nxt = din;
      MODE_HOLD:  q_nxt = q;
      MODE_DEMUX: q_nxt = hit & din;
      MODE_CLEAR: q_nxt = 1'b0;
      default:    q_nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end

endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
  import alx_pkg::*;
#(
  parameter int NUM_OUT = 8,
  localparam int ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  sel_addr,
  input  logic               din,
  input  logic               en_n,
  input  logic               clr_n,
  output logic [NUM_OUT-1:0] q_out
);

  alx_mode_e          mode;
  logic [NUM_OUT-1:0] hit;

  alx_mode_decode u_mode (
    .en_n  (en_n),
    .clr_n (clr_n),
    .mode  (mode)
  );

  alx_sel_decode #(.NUM_OUT(NUM_OUT)) u_sel (
    .sel (sel_addr),
    .hit (hit)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    alx_bit_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .mode (mode),
      .hit  (hit[i]),
      .din  (din),
      .q    (q_out[i])
    );
  end

endmodule

// File: rtl/alx_checker.sv
module alx_checker #(
  parameter int NUM_OUT = 8,
  localparam int ADDR_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  sel_addr,
  input logic               din,
  input logic               en_n,
  input logic               clr_n,
  input logic [NUM_OUT-1:0] q_out
);

  logic [NUM_OUT-1:0] sel_mask;
  logic               in_write;
  logic               in_demux;

  assign sel_mask = {{(NUM_OUT-1){1'b0}}, 1'b1} << sel_addr;
  assign in_write = !en_n && clr_n;
  assign in_demux = !en_n && !clr_n;

  // R1: selected bit takes the data bit
  p_write_sel_r1: assert property (@(posedge clk) disable iff (rst)
    in_write |=> ((q_out & $past(sel_mask)) == ($past(din) ? $past(sel_mask) : '0)));

  // R1: unselected bits keep their values
  p_write_keep_r1: assert property (@(posedge clk) disable iff (rst)
    in_write |=> ((q_out & ~$past(sel_mask)) == ($past(q_out) & ~$past(sel_mask))));

  // R2: hold leaves the bank untouched
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr_n) |=> $stable(q_out));

  // R3: demultiplex yields the steered data bit only
  p_demux_r3: assert property (@(posedge clk) disable iff (rst)
    in_demux |=> (q_out == ($past(din) ? $past(sel_mask) : '0)));

  // R3: at most one output high after demultiplex
  p_demux_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    in_demux |=> $onehot0(q_out));

  // R4: clear zeroes everything
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr_n) |=> (q_out == '0));

  // R7: reset zeroes everything
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (q_out == '0));

  // R9: select code must not move between back-to-back writes
  p_sel_steady_r9: assert property (@(posedge clk) disable iff (rst)
    (in_write && $past(!en_n && clr_n)) |-> $stable(sel_addr));

endmodule

bind addr_latch_demux alx_checker #(.NUM_OUT(NUM_OUT)) u_alx_checker (
  .clk      (clk),
  .rst      (rst),
  .sel_addr (sel_addr),
  .din      (din),
  .en_n     (en_n),
  .clr_n    (clr_n),
  .q_out    (q_out)
);

// File: tb/tb_addr_latch_demux.sv
module tb_addr_latch_demux;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_OUT    = 8;
  localparam int ADDR_W     = 3;
  localparam int WATCHDOG   = 20000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [ADDR_W-1:0]  sel_addr = '0;
  logic               din = 1'b0;
  logic               en_n = 1'b1;
  logic               clr_n = 1'b1;
  logic [NUM_OUT-1:0] q_out;

  typedef struct {
    logic [NUM_OUT-1:0] exp;
    string              tag;
  } sb_item_t;

  sb_item_t           sb_q[$];
  logic [NUM_OUT-1:0] model = '0;
  int                 n_checks = 0;
  int                 n_fails  = 0;
  bit                 finished = 1'b0;

  addr_latch_demux #(.NUM_OUT(NUM_OUT)) dut (
    .clk      (clk),
    .rst      (rst),
    .sel_addr (sel_addr),
    .din      (din),
    .en_n     (en_n),
    .clr_n    (clr_n),
    .q_out    (q_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: applies inputs at the falling edge, predicts the next output
  task automatic step(input logic r, input logic [ADDR_W-1:0] a, input logic d,
                      input logic en, input logic cl, input string tag);
    sb_item_t it;
    @(negedge clk);
    rst = r; sel_addr = a; din = d; en_n = en; clr_n = cl;
    if (r) model = '0;
    else begin
      case ({en, cl})
        2'b01: model[a] = d;
        2'b11: ;
        2'b00: begin model = '0; model[a] = d; end
        default: model = '0;
      endcase
    end
    it.exp = model;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares just after each rising edge
  initial begin
    sb_item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_checks++;
        if (q_out !== it.exp) begin
          n_fails++;
          $display("FAIL %s: q_out=%b expected=%b at %0t", it.tag, q_out, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected end before %0d cycles", WATCHDOG);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    repeat (3) step(1'b1, 3'd5, 1'b1, 1'b0, 1'b1, "R7 reset state");
    step(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, "R2 hold after reset");

    // R1/R5: set every bit, address moved only during hold
    for (int k = 0; k < NUM_OUT; k++) begin
      step(1'b0, ADDR_W'(k), 1'b0, 1'b1, 1'b1, "R2 hold while moving select");
      step(1'b0, ADDR_W'(k), 1'b1, 1'b0, 1'b1, "R1 R5 write one bit");
    end

    // R2: hold ignores select and data
    for (int k = 0; k < NUM_OUT; k++)
      step(1'b0, ADDR_W'(7 - k), k[0], 1'b1, 1'b1, "R2 hold ignores inputs");

    // R1: clear individual bits back to zero, pattern 0x5A remains
    step(1'b0, 3'd0, 1'b0, 1'b1, 1'b1, "R2 hold");
    step(1'b0, 3'd0, 1'b0, 1'b0, 1'b1, "R1 write zero bit0");
    step(1'b0, 3'd2, 1'b0, 1'b1, 1'b1, "R2 hold");
    step(1'b0, 3'd2, 1'b0, 1'b0, 1'b1, "R1 write zero bit2");
    step(1'b0, 3'd5, 1'b0, 1'b1, 1'b1, "R2 hold");
    step(1'b0, 3'd5, 1'b0, 1'b0, 1'b1, "R1 write zero bit5");
    step(1'b0, 3'd7, 1'b0, 1'b1, 1'b1, "R2 hold");
    step(1'b0, 3'd7, 1'b0, 1'b0, 1'b1, "R1 write zero bit7");

    // R6: back-to-back writes on a fixed select, data toggling
    step(1'b0, 3'd6, 1'b0, 1'b1, 1'b1, "R2 hold");
    for (int n = 0; n < 6; n++)
      step(1'b0, 3'd6, n[0], 1'b0, 1'b1, "R6 consecutive writes");

    // R3/R5: demultiplex every select with data high and low
    for (int k = 0; k < NUM_OUT; k++) begin
      step(1'b0, ADDR_W'(k), 1'b1, 1'b0, 1'b0, "R3 R5 demux data high");
      step(1'b0, ADDR_W'(k), 1'b0, 1'b0, 1'b0, "R3 demux data low");
    end

    // R8: demultiplex then hold keeps the pattern
    step(1'b0, 3'd3, 1'b1, 1'b0, 1'b0, "R3 demux before hold");
    for (int n = 0; n < 4; n++)
      step(1'b0, ADDR_W'(n), ~n[0], 1'b1, 1'b1, "R8 hold keeps demux pattern");

    // write on top of demux result, then R4 clear with assorted inputs
    step(1'b0, 3'd1, 1'b1, 1'b0, 1'b1, "R1 write over demux pattern");
    for (int n = 0; n < 4; n++)
      step(1'b0, ADDR_W'(2 * n + 1), 1'b1, 1'b1, 1'b0, "R4 clear ignores inputs");

    // rebuild a pattern, then R7 reset mid-operation
    step(1'b0, 3'd4, 1'b1, 1'b0, 1'b1, "R1 write after clear");
    step(1'b0, 3'd4, 1'b1, 1'b0, 1'b1, "R6 repeated write");
    step(1'b1, 3'd4, 1'b1, 1'b0, 1'b1, "R7 reset overrides write");
    step(1'b1, 3'd2, 1'b1, 1'b0, 1'b0, "R7 reset overrides demux");
    step(1'b0, 3'd2, 1'b1, 1'b1, 1'b1, "R7 hold after reset stays zero");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule